// File: doc/BRIEF.md
# SPI Mode-3 Slave Streaming Transmitter

This block is the slave end of an SPI link. A host inside the chip pushes bytes into a transmit queue, and the external master pulls them out over MISO. The link runs with the clock idling high: data moves out on the falling edge and is sampled on the rising edge. Each byte the master sends on MOSI is delivered to the host as a byte with a one-cycle strobe. When the queue is empty, the slave fills the link with zero bytes, so the master may clock out fixed-size blocks at any time.

A data-ready output tells the master that packet bytes are waiting. The host marks the final byte of each packet as it writes it. Data-ready drops when only the last one or two bytes of the head packet remain in the queue. A master that reads only while data-ready is high must therefore finish the packet by parsing it. If the host writes into a full queue, the whole queue is thrown away, including that byte and any partial packet. Data-ready is then held high while only zeros come out, until the next host write. A sticky overflow flag records the event.

Chip select works on its level. A low level enables shifting, and no falling edge is needed to start. A high level resets the bit counter and both shift registers, which resynchronises the link on a byte boundary. All SPI pins are brought into the system clock domain through synchronisers, so the system clock must run at least eight times the SCLK rate.

Top module: `spis_stream_tx`

## Requirements
- R1: After reset, spi_miso, data_ready, rx_stb and ovf_flag are all 0.
- R2: Queued bytes leave on MISO in write order, most significant bit first. Each bit is updated after an SCLK falling edge and stays stable through the following rising edge.
- R3: MOSI is sampled on SCLK rising edges, most significant bit first. After the eighth rising edge, rx_byte carries the byte and rx_stb pulses high for exactly one clock.
- R4: A byte slot that starts while the queue is empty shifts out 0x00.
- R5: Chip select is level-sensitive. A low level at reset release is enough to transfer. While it is high, the bit counter and shift registers are cleared. A byte cut short by chip select going high is dropped: it is not re-queued and no rx_stb is produced for it. The next byte starts on a boundary.
- R6: Outside the overflow hold, data_ready is 1 exactly when the queue is non-empty and neither the head entry nor the entry behind it carries the packet-end mark. It follows the queue state one clock later.
- R7: A write while the queue holds DEPTH entries empties the queue and discards the written byte. Later byte slots shift out 0x00 until new data is written.
- R8: After an overflow, data_ready stays 1 until the next host write. From that write on, it follows R6.
- R9: ovf_flag is set by an overflow and stays set until ovf_clr is pulsed. If both happen in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from master, idles high |
| spi_cs_n | input | 1 | Chip select, active low, level-sensitive |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| data_ready | output | 1 | High while packet bytes are pending |
| tx_wr | input | 1 | Host write strobe into the transmit queue |
| tx_byte | input | 8 | Byte to queue |
| tx_last | input | 1 | Marks the written byte as the last of its packet |
| rx_byte | output | 8 | Last byte received on MOSI |
| rx_stb | output | 1 | One-cycle strobe for rx_byte |
| ovf_flag | output | 1 | Sticky overflow indication |
| ovf_clr | input | 1 | Write-one clear of ovf_flag |

## Verification
The bench builds the block with a queue depth of 8 and the default two-stage synchronisers. With that depth, filling the queue and forcing an overflow takes only a handful of writes. It also makes the data-ready rule checkable for every packet length from one byte up to most of the queue. With the queue empty, all 256 MOSI values are swept through a full byte each, which checks capture and zero fill together. Packet sweeps and the cut-short-byte case are compared against a queue model held in the bench.

// File: rtl/spis_pkg.sv
// Shared types for the SPI streaming slave.
// Assumes byte-wide transfers; the queue entry carries a packet-end mark.
package spis_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } q_entry_t;
endpackage

// File: rtl/spis_sync.sv
// Multi-bit flop-chain synchroniser.
// Each bit is synchronised on its own (suitable only for independent,
// slowly changing levels). RST_VAL gives the idle level per bit.
module spis_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the asynchronous level through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spis_txq.sv
// Transmit queue with packet-end marks, overflow flush, data-ready and
// sticky overflow flag.
// Assumes at most one write and one pop per cycle; pop is only issued
// while the queue is non-empty. A write into a full queue clears it.
module spis_txq
    import spis_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic              empty,
    output logic [BYTE_W-1:0] head_data,
    output logic              dr,
    output logic              ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    q_entry_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr, rd_nxt;
    logic [CW-1:0]   cnt;
    logic            full, wr_ok, ovf_evt;
    logic            hold_q, dr_q, ovf_q;
    logic            head_last, nxt_last, dr_calc;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == FULL_CNT);
    assign wr_ok   = wr_en && !full;
    assign ovf_evt = wr_en && full;
    assign empty   = (cnt == '0);
    assign rd_nxt  = bump(rd_ptr);

    assign head_data = mem[rd_ptr].data;
    assign head_last = mem[rd_ptr].last;
    assign nxt_last  = mem[rd_nxt].last;

    // Store an accepted byte with its packet-end mark.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= '{last: wr_last, data: wr_data};
        end
    end

    // Pointer and occupancy update; overflow resets everything.
    always_ff @(posedge clk) begin
        if (!rst_n || ovf_evt) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (pop)   rd_ptr <= rd_nxt;
            case ({wr_ok, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Data-ready rule: pending bytes, head packet not in its last two.
    always_comb begin
        dr_calc = hold_q;
        if (!empty && !head_last && !((cnt >= CW'(2)) && nxt_last)) begin
            dr_calc = 1'b1;
        end
    end

    // Overflow hold: set on flush, released by the next write.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= 1'b0;
        else if (ovf_evt) hold_q <= 1'b1;
        else if (wr_en)   hold_q <= 1'b0;
    end

    // Register the data-ready output.
    always_ff @(posedge clk) begin
        if (!rst_n) dr_q <= 1'b0;
        else        dr_q <= dr_calc;
    end

    // Sticky overflow flag with write-one clear; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_evt) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign dr  = dr_q;
    assign ovf = ovf_q;

    AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> (cnt == '0)); // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
    AST_HOLD_DR:    assert property (@(posedge clk) disable iff (!rst_n) hold_q |=> dr_q); // R8
    AST_DR_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) (empty && !hold_q) |=> !dr_q); // R6
    AST_OVF_SET:    assert property (@(posedge clk) disable iff (!rst_n) ovf_evt |=> ovf_q); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !ovf_clr) |=> ovf_q); // R9
endmodule

// File: rtl/spis_shifter.sv
// Mode-3 SPI slave shifter working on synchronised pins.
// Assumes sclk/cs_n/mosi are already in the clk domain and that clk
// is at least 8x SCLK. Loads a byte (or zero) at each byte boundary on
// the falling edge; captures MOSI on rising edges.
module spis_shifter
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_head,
    output logic              pop,
    output logic              miso,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

    logic              sclk_d, rise, fall, cs_act, at_boundary;
    logic [BW-1:0]     bcnt;
    logic [BYTE_W-1:0] tx_sh, rx_sh, load_byte, rx_next;

    assign cs_act      = !cs_n_s;
    assign rise        = sclk_s && !sclk_d;
    assign fall        = !sclk_s && sclk_d;
    assign at_boundary = (bcnt == '0);
    assign load_byte   = q_empty ? '0 : q_head;
    assign rx_next     = {rx_sh[BYTE_W-2:0], mosi_s};
    assign pop         = cs_act && fall && at_boundary && !q_empty;

    // Remember the previous synchronised SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b1;
        else        sclk_d <= sclk_s;
    end

    // Shift engine: cleared while deselected, else driven by SCLK edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            bcnt     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            miso     <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (fall) begin
                if (at_boundary) begin
                    miso  <= load_byte[BYTE_W-1];
                    tx_sh <= {load_byte[BYTE_W-2:0], 1'b0};
                end else begin
                    miso  <= tx_sh[BYTE_W-1];
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
            if (rise) begin
                rx_sh <= rx_next;
                if (bcnt == LAST_BIT) begin
                    bcnt     <= '0;
                    rx_valid <= 1'b1;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // Hold the last complete received byte for the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rx_data <= '0;
        else if (cs_act && rise && bcnt == LAST_BIT) rx_data <= rx_next;
    end

    AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |=> (bcnt == '0 && !rx_valid && !miso)); // R5
    AST_RX_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R3
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (cs_act && fall && at_boundary && q_empty) |=> !miso); // R4
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cs_act && !fall && $past(cs_act)) |=> $stable(miso)); // R2
endmodule

// File: rtl/spis_stream_tx.sv
// Top of the SPI mode-3 streaming slave: synchronisers, shifter and
// transmit queue. Assumes clk runs at least 8x SCLK and that the host
// marks each packet's final byte with tx_last.
module spis_stream_tx
    import spis_pkg::*;
#(
    parameter int DEPTH       = 4096,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              data_ready,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_last,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_stb,
    output logic              ovf_flag,
    input  logic              ovf_clr
);
    logic [2:0]        pins_s;
    logic              pop, q_empty;
    logic [BYTE_W-1:0] q_head;

    // Bring pins into clk domain: bit0 SCLK, bit1 CS_N (idle high), bit2 MOSI.
    spis_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_mosi, spi_cs_n, spi_sclk}),
        .sync_o (pins_s)
    );

    spis_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[0]),
        .cs_n_s  (pins_s[1]),
        .mosi_s  (pins_s[2]),
        .q_empty (q_empty),
        .q_head  (q_head),
        .pop     (pop),
        .miso    (spi_miso),
        .rx_data (rx_byte),
        .rx_valid(rx_stb)
    );

    spis_txq #(
        .DEPTH(DEPTH)
    ) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tx_wr),
        .wr_data  (tx_byte),
        .wr_last  (tx_last),
        .pop      (pop),
        .ovf_clr  (ovf_clr),
        .empty    (q_empty),
        .head_data(q_head),
        .dr       (data_ready),
        .ovf      (ovf_flag)
    );
endmodule

// File: tb/tb_spis_stream_tx.sv
module tb_spis_stream_tx;
    localparam int DEPTH = 8;
    localparam int HALF  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1, cs_n = 1'b0, mosi = 1'b0;
    logic       miso, dr, rx_stb, ovf;
    logic       wr = 1'b0, last = 1'b0, clr = 1'b0;
    logic [7:0] wdata = '0, rx_byte;

    int n_chk = 0, n_fail = 0, rx_cnt = 0;
    logic [7:0] rx_last = '0;
    logic [8:0] mq [$];
    logic       hold = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spis_stream_tx #(.DEPTH(DEPTH), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .data_ready(dr),
        .tx_wr(wr), .tx_byte(wdata), .tx_last(last),
        .rx_byte(rx_byte), .rx_stb(rx_stb), .ovf_flag(ovf), .ovf_clr(clr)
    );

    always @(negedge clk) if (rx_stb) begin rx_last = rx_byte; rx_cnt++; end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_dr();
        if (hold) return 1'b1;
        if (mq.size() == 0) return 1'b0;
        if (mq[0][8]) return 1'b0;
        if (mq.size() > 1 && mq[1][8]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic put(input logic [7:0] d, input logic l);
        @(negedge clk); wr = 1'b1; wdata = d; last = l;
        @(negedge clk); wr = 1'b0; last = 1'b0;
        if (mq.size() == DEPTH) begin mq.delete(); hold = 1'b1; end
        else begin mq.push_back({l, d}); hold = 1'b0; end
        repeat (2) @(negedge clk);
        chk("R6 dr after write", dr, exp_dr());
    endtask

    task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); sclk = 1'b0; mosi = mo[7-i];
            repeat (HALF - 1) @(negedge clk);
            mi = {mi[6:0], miso};
            @(negedge clk); sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    // Full byte with model pop and checks on MISO, MOSI capture and DR.
    task automatic byte_chk(input string req, input logic [7:0] mo);
        logic [7:0] mi, exp_mi;
        int c0;
        c0 = rx_cnt;
        exp_mi = (mq.size() > 0) ? mq[0][7:0] : 8'h00;
        if (mq.size() > 0) void'(mq.pop_front());
        xfer(mo, 8, mi);
        chk(req, mi, exp_mi);
        chk("R3 rx strobe count", rx_cnt, c0 + 1);
        chk("R3 rx byte", rx_last, mo);
        chk("R6 dr after byte", dr, exp_dr());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] mi;
        int c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 miso", miso, 0); chk("R1 dr", dr, 0);
        chk("R1 rx_stb", rx_stb, 0); chk("R1 ovf", ovf, 0);

        // R4/R3/R5: CS low since reset, full MOSI sweep on an empty queue.
        for (int v = 0; v < 256; v++) byte_chk("R4 zero fill", 8'(v));

        // R2/R6: packet lengths 1..6, drained plus one extra zero slot.
        for (int len = 1; len <= 6; len++) begin
            for (int k = 0; k < len; k++) put(8'(8'h31 * (len + 1) + 8'h5B * k), (k == len - 1));
            for (int k = 0; k <= len; k++) byte_chk("R2 miso byte order", 8'(8'hA5 ^ k));
        end

        // R6: two packets queued back to back.
        put(8'hC1, 1'b0); put(8'hC2, 1'b0); put(8'hC3, 1'b1);
        put(8'hD1, 1'b0); put(8'hD2, 1'b0); put(8'hD3, 1'b0); put(8'hD4, 1'b1);
        for (int k = 0; k < 8; k++) byte_chk("R2 two packets", 8'(k));

        // R5: cut-short byte is dropped, no strobe, next byte on boundary.
        put(8'h96, 1'b0); put(8'h69, 1'b1);
        c0 = rx_cnt;
        void'(mq.pop_front());
        xfer(8'hF0, 4, mi);
        @(negedge clk); cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 no strobe for partial byte", rx_cnt, c0);
        chk("R5 miso low while deselected", miso, 0);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
        byte_chk("R5 resync byte", 8'h3C);
        byte_chk("R5 queue drained", 8'h00);

        // R7/R8/R9: fill, overflow, zero output under held DR.
        for (int k = 0; k < DEPTH; k++) put(8'(8'h10 + k), 1'b0);
        chk("R9 no flag when just full", ovf, 0);
        put(8'hEE, 1'b1);
        chk("R9 flag set", ovf, 1);
        chk("R8 dr held", dr, 1);
        byte_chk("R7 zero after flush", 8'h11);
        byte_chk("R7 still zero", 8'h22);
        chk("R8 dr still held", dr, 1);
        put(8'h5A, 1'b1);
        chk("R8 dr released by write", dr, 0);
        byte_chk("R7 new data after flush", 8'h33);
        chk("R9 flag sticky", ovf, 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared", ovf, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule